// File: doc/BRIEF.md
# Arm Capacitor Voltage Balancer

This block chooses which cells of one converter arm are inserted during the next sampling period so that the cell capacitor voltages stay close to each other. Each cell reports its capacitor voltage once per sample. On each sampling strobe the block ranks the cells by voltage in ascending order. It then marks the requested number of cells for insertion, taking cells from the low end or the high end of that ranking depending on the sign of the arm current.

When the arm current charges the inserted capacitors, the least charged cells are inserted. When it discharges them, the most charged cells are inserted. A parameterised delay line sits on the voltage inputs. It models a communication network that delivers the voltage reports a fixed number of samples late, so the balancing decisions can be studied on stale data. The insertion count and the current polarity are taken at the strobe itself and are not delayed.

Top module: `cvb_top`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first strobe, `ins_mask` is all zeros. The voltage history is cleared to zero.
- R2: `ins_mask` takes its new value on the clock edge at which `smp_stb` is sampled high. It is readable one cycle later and holds unchanged on every edge without a strobe.
- R3: After a strobe, the number of ones in `ins_mask` equals the saturated insertion count taken at that strobe. A count of zero gives an all-zero mask.
- R4: When `arm_charging` is 1, the selected cells are those with the lowest ranks (rank 0 up to count-1).
- R5: When `arm_charging` is 0, the selected cells are those with the highest ranks (rank NCELL-count up to NCELL-1).
- R6: Ranking is ascending by unsigned voltage. Cell i is field `cell_volts[i*VW +: VW]`. For equal voltages, the lower cell index gets the lower rank, so charging prefers lower indices and discharging prefers higher indices.
- R7: With parameter DELAY = D, the voltages ranked at a strobe are the ones presented at the strobe D strobes earlier. With D = 0 the current inputs are used. Before D strobes have occurred, the missing history reads as zero.
- R8: An `ins_req` value greater than NCELL is treated as NCELL, which selects every cell.
- R9: `ins_req` and `arm_charging` are used as presented at the strobe. Changes to them between strobes leave `ins_mask` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle sampling strobe |
| cell_volts | input | NCELL*VW | Packed cell capacitor voltages, cell i at bits i*VW +: VW |
| arm_charging | input | 1 | 1 = arm current charges inserted cells, 0 = discharges |
| ins_req | input | $clog2(NCELL+1) | Requested number of inserted cells |
| ins_mask | output | NCELL | One bit per cell, 1 = insert |

## Verification
The bench builds two copies of the block, both with five cells and 12-bit voltages. One copy uses a two-sample delay and the other uses none. The two-sample copy reaches the deepest delay of interest, including the strobes right after reset where zero history is still being ranked. The zero-delay copy covers the pass-through variant of the delay line. The five-cell arm makes the all-equal tie case and the over-range count (6 and 7 on a 3-bit input) reachable next to ordinary random patterns.

// File: rtl/cvb_pkg.sv
package cvb_pkg;

    // Direction of the arm current with respect to the inserted capacitors
    typedef enum logic {
        DIR_DISCHARGE = 1'b0,
        DIR_CHARGE    = 1'b1
    } arm_dir_e;

endpackage

// File: rtl/cvb_delay.sv
// Holds the last DEPTH strobe-captured voltage vectors; output is the oldest.
module cvb_delay #(
    parameter int NCELL = 5,
    parameter int VW    = 12,
    parameter int DEPTH = 2,
    localparam int BW   = NCELL * VW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic [BW-1:0] din,
    output logic [BW-1:0] dout
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign dout = din;
        end else begin : g_line
            logic [DEPTH-1:0][BW-1:0] hist_d, hist_q;

            always_comb begin
                hist_d = hist_q;
                if (stb) begin
                    hist_d[0] = din;
                    for (int i = 1; i < DEPTH; i++) begin
                        hist_d[i] = hist_q[i-1];
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist_q <= '0;
                end else begin
                    hist_q <= hist_d;
                end
            end

            assign dout = hist_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/cvb_rank.sv
// Ascending rank of each cell; equal voltages ordered by cell index.
module cvb_rank #(
    parameter int NCELL = 5,
    parameter int VW    = 12,
    localparam int RW   = (NCELL > 1) ? $clog2(NCELL) : 1
) (
    input  logic [NCELL*VW-1:0] volts,
    output logic [NCELL*RW-1:0] ranks
);

    generate
        for (genvar i = 0; i < NCELL; i++) begin : g_cell
            logic [RW-1:0] cnt;
            always_comb begin
                cnt = '0;
                for (int j = 0; j < NCELL; j++) begin
                    if (j != i) begin
                        if ((volts[j*VW +: VW] < volts[i*VW +: VW]) ||
                            ((volts[j*VW +: VW] == volts[i*VW +: VW]) && (j < i))) begin
                            cnt = cnt + RW'(1);
                        end
                    end
                end
            end
            assign ranks[i*RW +: RW] = cnt;
        end
    endgenerate

endmodule

// File: rtl/cvb_pick.sv
// Marks the cells whose rank falls inside the window chosen by current polarity.
module cvb_pick
    import cvb_pkg::*;
#(
    parameter int NCELL = 5,
    localparam int RW   = (NCELL > 1) ? $clog2(NCELL) : 1,
    localparam int CW   = $clog2(NCELL + 1)
) (
    input  logic [NCELL*RW-1:0] ranks,
    input  arm_dir_e            dir,
    input  logic [CW-1:0]       count,
    output logic [NCELL-1:0]    mask
);

    generate
        for (genvar i = 0; i < NCELL; i++) begin : g_sel
            always_comb begin
                if (dir == DIR_CHARGE) begin
                    mask[i] = int'(ranks[i*RW +: RW]) < int'(count);
                end else begin
                    mask[i] = (int'(ranks[i*RW +: RW]) + int'(count)) >= NCELL;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cvb_top.sv
module cvb_top
    import cvb_pkg::*;
#(
    parameter int NCELL = 5,
    parameter int VW    = 12,
    parameter int DELAY = 2,
    localparam int CW   = $clog2(NCELL + 1),
    localparam int RW   = (NCELL > 1) ? $clog2(NCELL) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_stb,
    input  logic [NCELL*VW-1:0] cell_volts,
    input  logic                arm_charging,
    input  logic [CW-1:0]       ins_req,
    output logic [NCELL-1:0]    ins_mask
);

    typedef struct packed {
        logic [NCELL-1:0] mask;
    } state_t;

    state_t state_d, state_q;

    logic [NCELL*VW-1:0] volts_used;
    logic [NCELL*RW-1:0] ranks;
    logic [CW-1:0]       count_sat;
    logic [NCELL-1:0]    pick_mask;
    arm_dir_e            dir;

    cvb_delay #(.NCELL(NCELL), .VW(VW), .DEPTH(DELAY)) u_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .stb  (smp_stb),
        .din  (cell_volts),
        .dout (volts_used)
    );

    cvb_rank #(.NCELL(NCELL), .VW(VW)) u_rank (
        .volts(volts_used),
        .ranks(ranks)
    );

    assign count_sat = (int'(ins_req) > NCELL) ? CW'(NCELL) : ins_req;
    assign dir       = arm_charging ? DIR_CHARGE : DIR_DISCHARGE;

    cvb_pick #(.NCELL(NCELL)) u_pick (
        .ranks(ranks),
        .dir  (dir),
        .count(count_sat),
        .mask (pick_mask)
    );

    always_comb begin
        state_d = state_q;
        if (smp_stb) begin
            state_d.mask = pick_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ins_mask = state_q.mask;

endmodule

// File: rtl/cvb_top_chk.sv
module cvb_top_chk #(
    parameter int NCELL = 5,
    parameter int CW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_stb,
    input logic [CW-1:0]    ins_req,
    input logic [NCELL-1:0] ins_mask
);

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(ins_mask)); // R2

    AST_POPULATION: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> ($countones(ins_mask) ==
                     ((int'($past(ins_req)) > NCELL) ? NCELL : int'($past(ins_req))))); // R3

    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && (ins_req == '0)) |=> (ins_mask == '0)); // R3

    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && (int'(ins_req) >= NCELL)) |=> (&ins_mask)); // R8

endmodule

bind cvb_top cvb_top_chk #(.NCELL(NCELL), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_stb (smp_stb),
    .ins_req (ins_req),
    .ins_mask(ins_mask)
);

// File: tb/cvb_top_test.sv
`timescale 1ns/1ps
module cvb_top_test;

    localparam int NCELL = 5;
    localparam int VW    = 12;
    localparam int DLY   = 2;
    localparam int CW    = $clog2(NCELL + 1);

    logic                clk = 1'b0;
    logic                rst_n;
    logic                smp_stb;
    logic [NCELL*VW-1:0] cell_volts;
    logic                arm_charging;
    logic [CW-1:0]       ins_req;
    logic [NCELL-1:0]    mask_a, mask_b;

    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 0;
    string tag     = "R1";

    always #5 clk = ~clk;

    cvb_top #(.NCELL(NCELL), .VW(VW), .DELAY(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .cell_volts(cell_volts),
        .arm_charging(arm_charging), .ins_req(ins_req), .ins_mask(mask_a)
    );

    cvb_top #(.NCELL(NCELL), .VW(VW), .DELAY(0)) uut_d0 (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .cell_volts(cell_volts),
        .arm_charging(arm_charging), .ins_req(ins_req), .ins_mask(mask_b)
    );

    // Reference: sort (voltage, index) ascending, take from the polarity's end
    function automatic logic [NCELL-1:0] ref_mask(input logic [NCELL*VW-1:0] v,
                                                   input logic chg, input int cnt);
        int idx[NCELL];
        int k;
        logic [NCELL-1:0] m = '0;
        for (int i = 0; i < NCELL; i++) idx[i] = i;
        for (int a = 0; a < NCELL - 1; a++) begin
            for (int b = 0; b < NCELL - 1 - a; b++) begin
                int x = int'(v[idx[b]*VW +: VW]);
                int y = int'(v[idx[b+1]*VW +: VW]);
                if (x > y || (x == y && idx[b] > idx[b+1])) begin
                    int t = idx[b]; idx[b] = idx[b+1]; idx[b+1] = t;
                end
            end
        end
        k = (cnt > NCELL) ? NCELL : cnt;
        for (int r = 0; r < k; r++) begin
            if (chg) m[idx[r]] = 1'b1;
            else     m[idx[NCELL-1-r]] = 1'b1;
        end
        return m;
    endfunction

    logic [NCELL*VW-1:0] hist[$];
    logic [NCELL-1:0]    exp_a = '0, exp_b = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_a = '0;
            exp_b = '0;
            hist.delete();
            for (int i = 0; i < DLY; i++) hist.push_front('0);
        end else if (smp_stb) begin
            exp_a = ref_mask(hist[$], arm_charging, int'(ins_req));
            exp_b = ref_mask(cell_volts, arm_charging, int'(ins_req));
            hist.push_front(cell_volts);
            void'(hist.pop_back());
        end
    end

    // Compare both copies every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n !== 1'bx) begin
            vectors++;
            if (mask_a !== exp_a) begin
                fails++;
                $display("FAIL %s delay=%0d mask=%b expected=%b", tag, DLY, mask_a, exp_a);
            end
            if (mask_b !== exp_b) begin
                fails++;
                $display("FAIL %s delay=0 mask=%b expected=%b", tag, mask_b, exp_b);
            end
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    function automatic logic [NCELL*VW-1:0] pack(input int v0, input int v1, input int v2,
                                                  input int v3, input int v4);
        return {VW'(v4), VW'(v3), VW'(v2), VW'(v1), VW'(v0)};
    endfunction

    // One strobe, then idle cycles with unrelated input changes (R2, R9)
    task automatic sample(input logic [NCELL*VW-1:0] v, input logic chg, input int cnt,
                          input int idle);
        @(negedge clk);
        cell_volts   = v;
        arm_charging = chg;
        ins_req      = CW'(cnt);
        smp_stb      = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        for (int i = 0; i < idle; i++) begin
            cell_volts   = VW*NCELL'($urandom);
            arm_charging = ~arm_charging;
            ins_req      = CW'($urandom_range(0, 7));
            @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 1'b0; smp_stb = 1'b0; cell_volts = '0; arm_charging = 1'b0; ins_req = '0;
        repeat (3) @(negedge clk);
        tag = "R1";   // mask zero in reset and before any strobe
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        tag = "R7";   // first strobes on the delayed copy rank zero history
        sample(pack(900, 100, 500, 300, 700), 1'b1, 2, 2);
        sample(pack(10, 20, 30, 40, 50), 1'b0, 2, 2);
        sample(pack(400, 400, 100, 800, 50), 1'b1, 3, 2);

        tag = "R4";   // charging picks lowest
        sample(pack(300, 100, 200, 500, 400), 1'b1, 2, 1);
        sample(pack(5, 4, 3, 2, 1), 1'b1, 1, 1);
        tag = "R5";   // discharging picks highest
        sample(pack(300, 100, 200, 500, 400), 1'b0, 3, 1);
        sample(pack(1, 2, 3, 4, 5), 1'b0, 1, 1);

        tag = "R6";   // all equal: charge -> low indices, discharge -> high indices
        sample(pack(777, 777, 777, 777, 777), 1'b1, 2, 1);
        sample(pack(777, 777, 777, 777, 777), 1'b0, 2, 1);
        sample(pack(777, 777, 777, 777, 777), 1'b1, 2, 1);
        sample(pack(200, 100, 200, 100, 200), 1'b0, 2, 1);

        tag = "R3";   // zero and full counts
        sample(pack(11, 22, 33, 44, 55), 1'b1, 0, 1);
        sample(pack(11, 22, 33, 44, 55), 1'b0, 5, 1);
        tag = "R8";   // over-range counts saturate
        sample(pack(11, 22, 33, 44, 55), 1'b1, 6, 1);
        sample(pack(11, 22, 33, 44, 55), 1'b0, 7, 1);

        tag = "R9";   // long idle windows with changing controls
        sample(pack(60, 50, 40, 30, 20), 1'b1, 2, 8);

        tag = "R2";   // random patterns, back-to-back and spaced strobes
        for (int n = 0; n < 300; n++) begin
            sample(VW*NCELL'($urandom) & {NCELL{12'h01F}}, 1'($urandom),
                   $urandom_range(0, 7), $urandom_range(0, 3));
        end

        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule